// File: doc/BRIEF.md
# Cascadable Programmable Counter Digit

This block is one digit of a synchronous up-counter. It holds a small count that can be cleared, preset from a parallel bus, advanced, or held. Two parameters choose the variant at build time. One picks the modulus: full binary range, or decade (ten states). The other picks how the clear acts: on the next rising clock edge, or at once, without waiting for the clock.

Two count enables gate the advance. The count moves only while both are high. Only the second enable, the carry-forward enable, reaches the carry output. The carry output is high while that enable is high and the digit sits at its last state. Wiring a digit's carry into both enables of the next digit therefore builds a wide synchronous counter with no extra logic: each higher digit steps on the same clock edge on which every lower digit wraps.

Top module: `progCounter4`

## Requirements
- R1: A low `clearN` sets `count` to zero in both variants. Clear has the highest priority.
- R2: With `ASYNC_CLEAR=0`, a low `clearN` changes nothing before the next rising edge of `clk`. After that edge, `count` is zero.
- R3: With `ASYNC_CLEAR=1`, `count` goes to zero as soon as `clearN` falls, without a clock edge and whatever `loadN`, `enP` and `enT` are doing. It stays zero while `clearN` is low.
- R4: When `clearN` is high and `loadN` is low, `count` takes the value of `preset` on the next rising edge, whatever the enables are.
- R5: When clear and load are both inactive, `count` rises by one on a rising edge only if `enP` and `enT` are both high. Otherwise it holds its value.
- R6: `carryOut` is combinational and equals `enT` AND (`count` == terminal value). The terminal value is 15 for binary and 9 for decade. `enP` has no effect on `carryOut`.
- R7: An enabled count wraps from the terminal value to 0: from 15 in binary (`IS_DECADE=0`) and from 9 in decade (`IS_DECADE=1`).
- R8: In the decade variant, a loaded value above 9 returns to 0 on the next enabled count, with `carryOut` low.
- R9: Three decade digits, with each `carryOut` driving both enables of the next digit, count 000 to 999 synchronously and wrap to 000. The top carry is high only at 999 while the chain is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Active-low clear; synchronous or immediate, set by `ASYNC_CLEAR` |
| loadN | input | 1 | Active-low synchronous parallel load |
| preset | input | WIDTH | Value taken on load |
| enP | input | 1 | Count enable that gates only the advance |
| enT | input | 1 | Count enable that also gates `carryOut` |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | Terminal-count carry, gated by `enT` |

## Verification
Clear and load can be requested on the same edge. So can load and an enabled count. The bench provokes both cases: it drops `clearN` and `loadN` together with both enables high, and it loads with the enables high. A correct design must give zero in the first case and the preset in the second, never an incremented value. In the immediate-clear digits, the clear is also asserted between edges while load and enable are active. The outputs are then read before any clock edge arrives, which separates an immediate clear from a clear that waits for the clock.

// File: rtl/progCnt_pkg.sv
package progCnt_pkg;
  // Strobes from control to datapath; at most one is active at a time.
  typedef struct packed {
    logic clr;   // synchronous clear (sync variant only)
    logic load;  // take preset
    logic inc;   // advance by one
  } cntStrobes_t;
endpackage

// File: rtl/cntCtrl.sv
module cntCtrl
  import progCnt_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enP,
  input  logic        enT,
  input  logic        atTerm,
  output cntStrobes_t strb,
  output logic        carryOut
);
  logic syncClr;

  generate
    if (ASYNC_CLEAR) begin : g_asyncClr
      // Clear acts through the datapath register's async reset.
      assign syncClr = 1'b0;
    end else begin : g_syncClr
      assign syncClr = ~clearN;
    end
  endgenerate

  // Priority: clear, then load, then count, then hold.
  always_comb begin
    strb.clr  = syncClr;
    strb.load = ~syncClr & ~loadN;
    strb.inc  = ~syncClr & loadN & enP & enT;
  end

  // Only the carry-forward enable reaches the carry output.
  assign carryOut = enT & atTerm;
endmodule

// File: rtl/cntPath.sv
module cntPath
  import progCnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int MODULUS     = 16,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             clearN,
  input  cntStrobes_t      strb,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             atTerm
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] nextQ;

  // Any state at or above the terminal value wraps, so out-of-range
  // decade values fall back to zero on the next count.
  always_comb begin
    if (strb.clr)       nextQ = '0;
    else if (strb.load) nextQ = preset;
    else if (strb.inc)  nextQ = (q >= TERM) ? '0 : q + 1'b1;
    else                nextQ = q;
  end

  generate
    if (ASYNC_CLEAR) begin : g_asyncReg
      always_ff @(posedge clk or negedge clearN) begin
        if (!clearN) q <= '0;
        else         q <= nextQ;
      end
    end else begin : g_syncReg
      always_ff @(posedge clk) begin
        q <= nextQ;
      end
    end
  endgenerate

  assign atTerm = (q == TERM);

  // R1
  clr_zero_chk: assert property (@(posedge clk)
    !clearN |=> (q == '0));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!clearN)
    strb.load |=> (q == $past(preset)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!clearN)
    (!strb.clr && !strb.load && !strb.inc) |=> $stable(q));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!clearN)
    (strb.inc && q < TERM) |=> (q == $past(q) + 1'b1));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!clearN)
    (strb.inc && q == TERM) |=> (q == '0));
endmodule

// File: rtl/progCounter4.sv
module progCounter4
  import progCnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit IS_DECADE   = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] preset,
  input  logic             enP,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  localparam int MODULUS = IS_DECADE ? 10 : (1 << WIDTH);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

  cntStrobes_t strb;
  logic        atTerm;

  cntCtrl #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_ctrl (
    .clearN  (clearN),
    .loadN   (loadN),
    .enP     (enP),
    .enT     (enT),
    .atTerm  (atTerm),
    .strb    (strb),
    .carryOut(carryOut)
  );

  cntPath #(.WIDTH(WIDTH), .MODULUS(MODULUS), .ASYNC_CLEAR(ASYNC_CLEAR)) u_path (
    .clk   (clk),
    .clearN(clearN),
    .strb  (strb),
    .preset(preset),
    .q     (count),
    .atTerm(atTerm)
  );

  // R6
  carry_term_chk: assert property (@(posedge clk) disable iff (!clearN)
    carryOut |-> (enT && count == TERM));
endmodule

// File: tb/test_progCounter4.sv
module test_progCounter4;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0]  bCnt;
    logic        bCy;
    logic [11:0] dCnt;
    logic        dCy;
    string       req;
  } sbItem_t;

  sbItem_t sbq[$];
  int nChecks = 0;
  int nFails  = 0;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Binary digit, clock-synchronous clear.
  logic       clrB = 1'b0, ldB = 1'b1, epB = 1'b0, etB = 1'b0;
  logic [3:0] preB = '0;
  logic [3:0] cntB;
  logic       cyB;

  progCounter4 #(.WIDTH(4), .IS_DECADE(1'b0), .ASYNC_CLEAR(1'b0)) i_progCounter4 (
    .clk(clk), .clearN(clrB), .loadN(ldB), .preset(preB),
    .enP(epB), .enT(etB), .count(cntB), .carryOut(cyB)
  );

  // Three decade digits, immediate clear, chained through the carry.
  logic       clrD = 1'b0, ldD = 1'b1, enD = 1'b0;
  logic [3:0] preD [3];
  logic [3:0] cntD [3];
  logic       cyD  [3];
  logic       chainEn [3];

  for (genvar k = 0; k < 3; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign chainEn[k] = enD;
    end else begin : g_next
      assign chainEn[k] = cyD[k-1];
    end
    progCounter4 #(.WIDTH(4), .IS_DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_digit (
      .clk(clk), .clearN(clrD), .loadN(ldD), .preset(preD[k]),
      .enP(chainEn[k]), .enT(chainEn[k]), .count(cntD[k]), .carryOut(cyD[k])
    );
  end

  // Reference state.
  logic [3:0] mB;
  logic [3:0] mD [3];

  function automatic logic [3:0] nextVal(logic [3:0] q, logic clr, logic ld,
                                         logic [3:0] p, logic en, logic [3:0] term);
    if (!clr)     return 4'd0;
    else if (!ld) return p;
    else if (en)  return (q >= term) ? 4'd0 : q + 4'd1;
    else          return q;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes what must follow the edge.
  task automatic step(logic cB, logic lB, logic [3:0] pB, logic eP, logic eT,
                      logic cD, logic lD, logic [3:0] p0, logic [3:0] p1,
                      logic [3:0] p2, logic eD, string req);
    sbItem_t it;
    logic e1, e2;
    @(negedge clk);
    clrB = cB; ldB = lB; preB = pB; epB = eP; etB = eT;
    clrD = cD; ldD = lD; preD[0] = p0; preD[1] = p1; preD[2] = p2; enD = eD;
    mB = nextVal(mB, cB, lB, pB, eP & eT, 4'd15);
    e1 = eD && mD[0] == 4'd9;
    e2 = e1 && mD[1] == 4'd9;
    mD[2] = nextVal(mD[2], cD, lD, p2, e2, 4'd9);
    mD[1] = nextVal(mD[1], cD, lD, p1, e1, 4'd9);
    mD[0] = nextVal(mD[0], cD, lD, p0, eD, 4'd9);
    it.bCnt = mB;
    it.bCy  = eT && mB == 4'd15;
    it.dCnt = {mD[2], mD[1], mD[0]};
    it.dCy  = eD && mD[0] == 4'd9 && mD[1] == 4'd9 && mD[2] == 4'd9;
    it.req  = req;
    sbq.push_back(it);
  endtask

  task automatic bOnly(logic cB, logic lB, logic [3:0] pB, logic eP, logic eT, string req);
    step(cB, lB, pB, eP, eT, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b0, req);
  endtask

  task automatic dOnly(logic cD, logic lD, logic [3:0] p0, logic [3:0] p1,
                       logic [3:0] p2, logic eD, string req);
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, cD, lD, p0, p1, p2, eD, req);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    sbItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check({it.req, " binary"}, {27'd0, cyB, cntB}, {27'd0, it.bCy, it.bCnt});
        check({it.req, " chain"}, {19'd0, cyD[2], cntD[2], cntD[1], cntD[0]},
              {19'd0, it.dCy, it.dCnt});
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    preD[0] = '0; preD[1] = '0; preD[2] = '0;
    mB = '0; mD[0] = '0; mD[1] = '0; mD[2] = '0;

    // R1 reset state: clear held low with load and enables active
    step(1'b0, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd3, 4'd3, 1'b1, "R1 clear");
    step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0, 1'b1, "R1 clear");

    // R5 R7 R6: binary counts through 15 -> 0 with carry at 15
    for (int i = 0; i < 20; i++) bOnly(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R7 count");
    // R4 load ignores idle enables
    bOnly(1'b1, 1'b0, 4'd13, 1'b0, 1'b0, "R4 load");
    // R5 hold with one enable low
    bOnly(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R5 hold");
    bOnly(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R5 hold");
    // R4 load beats an enabled count
    bOnly(1'b1, 1'b0, 4'd15, 1'b1, 1'b1, "R4 load");
    // R6 carry follows enT only; enP low, count 15
    bOnly(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R6 carry");
    bOnly(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R6 carry");
    bOnly(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R7 wrap");
    // R1 clear beats load and count
    bOnly(1'b1, 1'b0, 4'd9, 1'b0, 1'b0, "R4 load");
    bOnly(1'b0, 1'b0, 4'd5, 1'b1, 1'b1, "R1 priority");

    // R8 decade digit loaded above 9
    dOnly(1'b1, 1'b0, 4'd12, 4'd0, 4'd0, 1'b0, "R8 load");
    dOnly(1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b1, "R8 wrap");
    dOnly(1'b1, 1'b0, 4'd15, 4'd0, 4'd0, 1'b1, "R8 load");
    dOnly(1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b1, "R8 wrap");

    // R9 full wrap of the three-digit chain, plus a few more counts
    dOnly(1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, "R9 load");
    for (int i = 0; i < 1005; i++) dOnly(1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b1, "R9 cascade");
    // R5 chain hold when disabled
    dOnly(1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 1'b0, "R5 chain hold");

    // R2 binary: clear is seen only at the edge
    bOnly(1'b1, 1'b0, 4'd6, 1'b0, 1'b0, "R4 load");
    wait (sbq.size() == 0);
    @(negedge clk);
    clrB = 1'b0;
    #2;
    check("R2 before edge", {28'd0, cntB}, 32'd6);
    @(posedge clk);
    #2;
    check("R2 after edge", {28'd0, cntB}, 32'd0);

    // R3 chain: clear acts at once, between edges, against load and count
    @(negedge clk);
    #1;
    check("R3 nonzero start", {20'd0, cntD[2], cntD[1], cntD[0]}, 32'h005);
    ldD = 1'b0; preD[0] = 4'd7; enD = 1'b1;
    clrD = 1'b0;
    #1;
    check("R3 immediate", {19'd0, cyD[2], cntD[2], cntD[1], cntD[0]}, 32'd0);
    @(posedge clk);
    #2;
    check("R3 held", {20'd0, cntD[2], cntD[1], cntD[0]}, 32'd0);
    @(negedge clk);
    clrD = 1'b1; ldD = 1'b1; enD = 1'b0;
    #2;
    check("R3 released", {20'd0, cntD[2], cntD[1], cntD[0]}, 32'd0);

    finishRun();
  end
endmodule